// File: doc/BRIEF.md
# Deferred Register Write-Back Buffer

This block sits between the execute stage and the architectural register state of a core that issues two operations from one instruction word. It holds every register write produced while the word executes. Those writes become visible together, so neither operation can observe a result of the other. The register state it guards is sixteen 16-bit general registers and two 40-bit accumulators. Read ports always show the committed contents.

Each queued write carries a destination index, a keep-mask and a data value. When the core signals commit, the entries are folded into their destinations oldest first. Each destination becomes `(old AND keep) OR data`. The buffer is then empty. A discard strobe empties the buffer instead, and no register changes. A 32-bit write to a register pair is split into two 16-bit entries at enqueue time.

Top module: `deferred_wb_buffer`

## Requirements
- R1: After a clock edge with `rst_n` low, every general register and accumulator reads zero, `pending_count` is 0 and `enq_reject` is 0.
- R2: An accepted single write raises `pending_count` by one at the next edge, and no read port shows the pending value until a commit.
- R3: On commit, each entry sets its destination to `(old & keep) | data`, and the entries are applied in the order they were enqueued. A later entry to the same destination therefore works on the result of an earlier one.
- R4: An entry whose keep-mask is zero replaces its destination completely on commit.
- R5: A `discard` empties the buffer (`pending_count` 0 at the next edge) and leaves every register unchanged.
- R6: A commit empties the buffer. A write enqueued in the same cycle as a commit is kept and is not applied by that commit, so `pending_count` is 1 afterwards.
- R7: Destination codes 16 and 17 select accumulators 0 and 1. An accumulator entry keeps only bits 39:0 of the 48-bit keep-mask and data inputs.
- R8: With `enq_pair` set and destination N in 0..14, bits 31:16 of data and keep-mask go to register N, and bits 15:0 go to register N+1. This uses two entries.
- R9: A write that needs more entries than are free (16 in total) is dropped, `pending_count` is unchanged, and `enq_reject` is 1 for the following cycle.
- R10: A write to destination 18..31, or a pair write to destination 15 or above, is dropped and raises `enq_reject` for the following cycle.
- R11: When `commit` and `discard` are both high in a cycle, discard wins and no register changes.
- R12: A general-register entry uses only bits 15:0 of the data and keep-mask inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue a write this cycle |
| enq_pair | input | 1 | Write is a 32-bit register pair starting at `enq_dest` |
| enq_dest | input | 5 | Destination: 0..15 general register, 16..17 accumulator |
| enq_keep | input | 48 | Keep-mask: bits set here preserve the old value |
| enq_data | input | 48 | Value ORed in after masking |
| commit | input | 1 | Apply all pending entries |
| discard | input | 1 | Drop all pending entries |
| rd_gpr_idx | input | 4 | General register read index |
| rd_gpr_data | output | 16 | Committed general register value |
| rd_acc_sel | input | 1 | Accumulator read select |
| rd_acc_data | output | 40 | Committed accumulator value |
| pending_count | output | 5 | Number of pending entries |
| enq_reject | output | 1 | A write was dropped in the previous cycle |

## Verification
The merge is exercised with three kinds of keep-mask patterns. Zero masks show whether a write is a plain replace. Complementary byte masks on one register show whether entries apply in order or one overwrites the other. Inputs with stray high bits show whether general registers and accumulators are truncated correctly. Commit, discard and enqueue are also driven in every pairing within a single cycle, and the buffer is filled to exactly 16 entries and one past. These cases separate correct emptying and carry-over from slot arithmetic that is off by one. A long pseudo-random phase checks all eighteen registers against the reference model on every clock.

// File: rtl/dwb_pkg.sv
// Shared constants and the pending-entry type for the deferred write-back buffer.
// Assumes the accumulator is the widest destination, so an entry holds ACC_W bits.
package dwb_pkg;
    localparam int NGPR   = 16;
    localparam int GPR_W  = 16;
    localparam int NACC   = 2;
    localparam int ACC_W  = 40;
    localparam int VAL_W  = 48;
    localparam int DEST_W = 5;
    localparam int DEPTH  = 16;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [ACC_W-1:0]  keep;
        logic [ACC_W-1:0]  data;
    } dwb_entry_t;
endpackage

// File: rtl/dwb_queue.sv
// Pending-entry store. It accepts one write per cycle, splits pair writes into
// two entries, and empties itself on commit or discard.
// Assumes: a write in the same cycle as commit/discard lands in the emptied store.
module dwb_queue
    import dwb_pkg::*;
#(
    parameter int Q_DEPTH = DEPTH,
    parameter int Q_NGPR  = NGPR,
    parameter int Q_NACC  = NACC,
    parameter int Q_VAL_W = VAL_W,
    localparam int CNT_W  = $clog2(Q_DEPTH + 1)
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enq_valid,
    input  logic                  enq_pair,
    input  logic [DEST_W-1:0]     enq_dest,
    input  logic [Q_VAL_W-1:0]    enq_keep,
    input  logic [Q_VAL_W-1:0]    enq_data,
    input  logic                  clear,
    output dwb_entry_t [Q_DEPTH-1:0] entries,
    output logic [CNT_W-1:0]      count,
    output logic                  reject
);
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   free_slots;
    logic [CNT_W:0]   need;
    logic             dest_ok;
    logic             accept;
    dwb_entry_t       first_e;
    dwb_entry_t       second_e;

    // Decide whether the incoming write fits, and build its entries.
    always_comb begin
        base       = clear ? '0 : count;
        free_slots = (CNT_W+1)'(Q_DEPTH) - {1'b0, base};
        need       = enq_pair ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
        dest_ok    = enq_pair ? (int'(enq_dest) < Q_NGPR - 1)
                              : (int'(enq_dest) < Q_NGPR + Q_NACC);
        accept     = enq_valid && dest_ok && (free_slots >= need);

        first_e.dest  = enq_dest;
        second_e.dest = enq_dest + 1'b1;
        second_e.keep = {{(ACC_W-GPR_W){1'b0}}, enq_keep[GPR_W-1:0]};
        second_e.data = {{(ACC_W-GPR_W){1'b0}}, enq_data[GPR_W-1:0]};
        if (enq_pair) begin
            first_e.keep = {{(ACC_W-GPR_W){1'b0}}, enq_keep[2*GPR_W-1:GPR_W]};
            first_e.data = {{(ACC_W-GPR_W){1'b0}}, enq_data[2*GPR_W-1:GPR_W]};
        end else begin
            first_e.keep = enq_keep[ACC_W-1:0];
            first_e.data = enq_data[ACC_W-1:0];
        end
    end

    // Occupancy counter and reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            reject <= 1'b0;
        end else begin
            reject <= enq_valid && !accept;
            count  <= accept ? base + need[CNT_W-1:0] : base;
        end
    end

    // One storage slot per entry, written when the slot index matches.
    for (genvar i = 0; i < Q_DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[i] <= '0;
            end else if (accept && CNT_W'(i) == base) begin
                entries[i] <= first_e;
            end else if (accept && enq_pair && CNT_W'(i) == base + 1'b1) begin
                entries[i] <= second_e;
            end
        end
    end
endmodule

// File: rtl/dwb_merge.sv
// Combinational fold of all valid entries onto the committed register state,
// oldest entry first. Assumes destinations were range-checked at enqueue.
module dwb_merge
    import dwb_pkg::*;
#(
    parameter int M_DEPTH = DEPTH,
    parameter int M_NGPR  = NGPR,
    parameter int M_NACC  = NACC,
    localparam int CNT_W  = $clog2(M_DEPTH + 1),
    localparam int IDX_W  = $clog2(M_NGPR),
    localparam int AIDX_W = (M_NACC > 1) ? $clog2(M_NACC) : 1
)(
    input  dwb_entry_t [M_DEPTH-1:0]         entries,
    input  logic [CNT_W-1:0]                 count,
    input  logic [M_NGPR-1:0][GPR_W-1:0]     gpr_cur,
    input  logic [M_NACC-1:0][ACC_W-1:0]     acc_cur,
    output logic [M_NGPR-1:0][GPR_W-1:0]     gpr_nxt,
    output logic [M_NACC-1:0][ACC_W-1:0]     acc_nxt
);
    logic [DEST_W-1:0] d_cur;
    logic [DEST_W-1:0] a_off;

    // Apply each entry in enqueue order to a running copy of the state.
    always_comb begin
        gpr_nxt = gpr_cur;
        acc_nxt = acc_cur;
        d_cur   = '0;
        a_off   = '0;
        for (int i = 0; i < M_DEPTH; i++) begin
            if (CNT_W'(i) < count) begin
                d_cur = entries[i].dest;
                a_off = d_cur - DEST_W'(M_NGPR);
                if (int'(d_cur) < M_NGPR) begin
                    gpr_nxt[d_cur[IDX_W-1:0]] =
                        (gpr_nxt[d_cur[IDX_W-1:0]] & entries[i].keep[GPR_W-1:0])
                        | entries[i].data[GPR_W-1:0];
                end else begin
                    acc_nxt[a_off[AIDX_W-1:0]] =
                        (acc_nxt[a_off[AIDX_W-1:0]] & entries[i].keep)
                        | entries[i].data;
                end
            end
        end
    end
endmodule

// File: rtl/dwb_regstate.sv
// Architectural register state: general registers and accumulators, loaded
// only on an effective commit, with combinational read ports.
module dwb_regstate
    import dwb_pkg::*;
#(
    parameter int S_NGPR  = NGPR,
    parameter int S_NACC  = NACC,
    localparam int IDX_W  = $clog2(S_NGPR),
    localparam int AIDX_W = (S_NACC > 1) ? $clog2(S_NACC) : 1
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [S_NGPR-1:0][GPR_W-1:0]  gpr_in,
    input  logic [S_NACC-1:0][ACC_W-1:0]  acc_in,
    output logic [S_NGPR-1:0][GPR_W-1:0]  gpr_q,
    output logic [S_NACC-1:0][ACC_W-1:0]  acc_q,
    input  logic [IDX_W-1:0]              rd_gpr_idx,
    output logic [GPR_W-1:0]              rd_gpr_data,
    input  logic [AIDX_W-1:0]             rd_acc_sel,
    output logic [ACC_W-1:0]              rd_acc_data
);
    // Hold or replace the whole register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpr_q <= '0;
            acc_q <= '0;
        end else if (load) begin
            gpr_q <= gpr_in;
            acc_q <= acc_in;
        end
    end

    assign rd_gpr_data = gpr_q[rd_gpr_idx];
    assign rd_acc_data = acc_q[rd_acc_sel];
endmodule

// File: rtl/deferred_wb_buffer.sv
// Top level: queues register writes during one instruction word and merges them
// into the register state on commit; discard drops them and takes priority.
// Assumes commit/discard/enqueue are single-cycle strobes from the issue stage.
module deferred_wb_buffer
    import dwb_pkg::*;
#(
    parameter int B_DEPTH = DEPTH,
    parameter int B_NGPR  = NGPR,
    parameter int B_NACC  = NACC,
    parameter int B_VAL_W = VAL_W,
    localparam int CNT_W  = $clog2(B_DEPTH + 1),
    localparam int IDX_W  = $clog2(B_NGPR),
    localparam int AIDX_W = (B_NACC > 1) ? $clog2(B_NACC) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    input  logic               enq_pair,
    input  logic [DEST_W-1:0]  enq_dest,
    input  logic [B_VAL_W-1:0] enq_keep,
    input  logic [B_VAL_W-1:0] enq_data,
    input  logic               commit,
    input  logic               discard,
    input  logic [IDX_W-1:0]   rd_gpr_idx,
    output logic [GPR_W-1:0]   rd_gpr_data,
    input  logic [AIDX_W-1:0]  rd_acc_sel,
    output logic [ACC_W-1:0]   rd_acc_data,
    output logic [CNT_W-1:0]   pending_count,
    output logic               enq_reject
);
    dwb_entry_t [B_DEPTH-1:0]       entries;
    logic [B_NGPR-1:0][GPR_W-1:0]   gpr_q, gpr_nxt;
    logic [B_NACC-1:0][ACC_W-1:0]   acc_q, acc_nxt;
    logic                           apply;
    logic                           clear;

    assign apply = commit && !discard;
    assign clear = commit || discard;

    dwb_queue #(
        .Q_DEPTH(B_DEPTH), .Q_NGPR(B_NGPR), .Q_NACC(B_NACC), .Q_VAL_W(B_VAL_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_pair(enq_pair), .enq_dest(enq_dest),
        .enq_keep(enq_keep), .enq_data(enq_data), .clear(clear),
        .entries(entries), .count(pending_count), .reject(enq_reject)
    );

    dwb_merge #(
        .M_DEPTH(B_DEPTH), .M_NGPR(B_NGPR), .M_NACC(B_NACC)
    ) u_merge (
        .entries(entries), .count(pending_count),
        .gpr_cur(gpr_q), .acc_cur(acc_q),
        .gpr_nxt(gpr_nxt), .acc_nxt(acc_nxt)
    );

    dwb_regstate #(
        .S_NGPR(B_NGPR), .S_NACC(B_NACC)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .load(apply),
        .gpr_in(gpr_nxt), .acc_in(acc_nxt),
        .gpr_q(gpr_q), .acc_q(acc_q),
        .rd_gpr_idx(rd_gpr_idx), .rd_gpr_data(rd_gpr_data),
        .rd_acc_sel(rd_acc_sel), .rd_acc_data(rd_acc_data)
    );
endmodule

// File: rtl/dwb_checker.sv
// Temporal checks on the buffer's ports; attached to every instance by bind.
module dwb_checker #(
    parameter int C_DEPTH = 16,
    localparam int CNT_W  = $clog2(C_DEPTH + 1)
)(
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             commit,
    input logic             discard,
    input logic [3:0]       rd_gpr_idx,
    input logic [15:0]      rd_gpr_data,
    input logic             rd_acc_sel,
    input logic [39:0]      rd_acc_data,
    input logic [CNT_W-1:0] pending_count,
    input logic             enq_reject
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pending_count == '0) && !enq_reject);

    // R2
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_valid && !commit && !discard) |=> $stable(pending_count));

    // R5
    discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (discard && !enq_valid) |=> pending_count == '0);

    // R6
    commit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !enq_valid) |=> pending_count == '0);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !commit && !discard && pending_count == CNT_W'(C_DEPTH))
        |=> enq_reject && pending_count == CNT_W'(C_DEPTH));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_count <= CNT_W'(C_DEPTH));

    // R11
    gpr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && !discard) |=> (!$stable(rd_gpr_idx) || $stable(rd_gpr_data)));

    // R11
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && !discard) |=> (!$stable(rd_acc_sel) || $stable(rd_acc_data)));
endmodule

bind deferred_wb_buffer dwb_checker #(.C_DEPTH(B_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .commit(commit),
    .discard(discard), .rd_gpr_idx(rd_gpr_idx), .rd_gpr_data(rd_gpr_data),
    .rd_acc_sel(rd_acc_sel), .rd_acc_data(rd_acc_data),
    .pending_count(pending_count), .enq_reject(enq_reject)
);

// File: tb/sim_deferred_wb_buffer.sv
`timescale 1ns/1ps
module sim_deferred_wb_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0, enq_pair = 1'b0, commit = 1'b0, discard = 1'b0;
    logic [4:0]  enq_dest = '0;
    logic [47:0] enq_keep = '0, enq_data = '0;
    logic [3:0]  rd_gpr_idx = '0;
    logic        rd_acc_sel = 1'b0;
    logic [15:0] rd_gpr_data;
    logic [39:0] rd_acc_data;
    logic [4:0]  pending_count;
    logic        enq_reject;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference model
    logic [15:0] m_gpr [16];
    logic [39:0] m_acc [2];
    logic [4:0]  q_dest [$];
    logic [39:0] q_keep [$];
    logic [39:0] q_data [$];
    logic        m_rej;

    always #2 clk = ~clk;

    deferred_wb_buffer u0 (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_pair(enq_pair),
        .enq_dest(enq_dest), .enq_keep(enq_keep), .enq_data(enq_data),
        .commit(commit), .discard(discard), .rd_gpr_idx(rd_gpr_idx),
        .rd_gpr_data(rd_gpr_data), .rd_acc_sel(rd_acc_sel),
        .rd_acc_data(rd_acc_data), .pending_count(pending_count),
        .enq_reject(enq_reject)
    );

    task automatic check(input string tag, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "pending_count", 48'(pending_count), 48'(q_dest.size()));
        check(tag, "enq_reject", 48'(enq_reject), 48'(m_rej));
        for (int r = 0; r < 16; r++) begin
            rd_gpr_idx = 4'(r);
            #0.05;
            check(tag, $sformatf("gpr%0d", r), 48'(rd_gpr_data), 48'(m_gpr[r]));
        end
        for (int a = 0; a < 2; a++) begin
            rd_acc_sel = a[0];
            #0.05;
            check(tag, $sformatf("acc%0d", a), 48'(rd_acc_data), 48'(m_acc[a]));
        end
    endtask

    // One clock: drive, update model, sample after the edge.
    task automatic cyc(input logic ev, input logic pr, input logic [4:0] ds,
                       input logic [47:0] kp, input logic [47:0] dt,
                       input logic cm, input logic dc, input string tag);
        int need;
        logic ok;
        enq_valid = ev; enq_pair = pr; enq_dest = ds; enq_keep = kp; enq_data = dt;
        commit = cm; discard = dc;
        if (cm && !dc) begin
            for (int i = 0; i < q_dest.size(); i++) begin
                if (q_dest[i] < 16)
                    m_gpr[q_dest[i]] = (m_gpr[q_dest[i]] & q_keep[i][15:0]) | q_data[i][15:0];
                else
                    m_acc[q_dest[i]-16] = (m_acc[q_dest[i]-16] & q_keep[i]) | q_data[i];
            end
        end
        if (cm || dc) begin
            q_dest.delete(); q_keep.delete(); q_data.delete();
        end
        m_rej = 1'b0;
        if (ev) begin
            need = pr ? 2 : 1;
            ok = pr ? (ds < 15) : (ds < 18);
            if (ok && q_dest.size() + need <= 16) begin
                if (pr) begin
                    q_dest.push_back(ds);   q_keep.push_back(40'(kp[31:16])); q_data.push_back(40'(dt[31:16]));
                    q_dest.push_back(ds+1); q_keep.push_back(40'(kp[15:0]));  q_data.push_back(40'(dt[15:0]));
                end else begin
                    q_dest.push_back(ds); q_keep.push_back(kp[39:0]); q_data.push_back(dt[39:0]);
                end
            end else begin
                m_rej = 1'b1;
            end
        end
        @(posedge clk);
        #0.5;
        enq_valid = 0; enq_pair = 0; commit = 0; discard = 0;
        check_all(tag);
    endtask

    task automatic wr(input logic [4:0] ds, input logic [47:0] kp, input logic [47:0] dt, input string tag);
        cyc(1, 0, ds, kp, dt, 0, 0, tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < 16; i++) m_gpr[i] = '0;
        m_acc[0] = '0; m_acc[1] = '0; m_rej = 0;
        repeat (3) @(posedge clk);
        #0.5;
        check_all("R1");
        rst_n = 1;
        cyc(0, 0, 0, 0, 0, 0, 0, "R1");

        // R2: pending writes invisible
        wr(3, 0, 48'h1234, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, "R2");
        // R4: mask zero replaces
        cyc(0, 0, 0, 0, 0, 1, 0, "R4");
        wr(3, 0, 48'h5555, "R4");
        cyc(0, 0, 0, 0, 0, 1, 0, "R4");
        wr(3, 0, 48'h1234, "R4");
        cyc(0, 0, 0, 0, 0, 1, 0, "R4");
        // R3: ordered merge on one register -> AB56
        wr(3, 48'hFF00, 48'h0056, "R3");
        wr(3, 48'h00FF, 48'hAB00, "R3");
        cyc(0, 0, 0, 0, 0, 1, 0, "R3");
        // R12: high bits of gpr inputs ignored
        wr(5, 48'hFFFF_FFFF_0000, 48'hFFFF_FFFF_BEEF, "R12");
        cyc(0, 0, 0, 0, 0, 1, 0, "R12");
        // R7: accumulators keep low 40 bits
        wr(16, 48'h0, 48'hABCD_EF01_2345, "R7");
        wr(17, 48'hFF00_0000_0000, 48'h00FF_1122_3344, "R7");
        wr(17, 48'hFFFF_FFFF_FF00, 48'h0000_0000_0099, "R7");
        cyc(0, 0, 0, 0, 0, 1, 0, "R7");
        // R8: pair writes
        cyc(1, 1, 8, 48'h0, 48'hDEAD_BEEF, 0, 0, "R8");
        cyc(1, 1, 14, 48'h0, 48'hCAFE_F00D, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 1, 0, "R8");
        // R10: bad destinations
        cyc(1, 1, 15, 48'h0, 48'h1111_2222, 0, 0, "R10");
        wr(18, 0, 48'h77, "R10");
        wr(31, 0, 48'h77, "R10");
        cyc(1, 1, 16, 48'h0, 48'h1111_2222, 0, 0, "R10");
        // R5: discard
        wr(0, 0, 48'h9999, "R5");
        wr(16, 0, 48'h9999, "R5");
        cyc(0, 0, 0, 0, 0, 0, 1, "R5");
        cyc(0, 0, 0, 0, 0, 1, 0, "R5");
        // R6: commit with enqueue in same cycle
        wr(1, 0, 48'h0101, "R6");
        cyc(1, 0, 2, 0, 48'h0202, 1, 0, "R6");
        cyc(0, 0, 0, 0, 0, 1, 0, "R6");
        // R11: commit and discard together
        wr(4, 0, 48'h4444, "R11");
        cyc(0, 0, 0, 0, 0, 1, 1, "R11");
        cyc(0, 0, 0, 0, 0, 1, 0, "R11");
        // R9: fill to 16, overflow single and pair
        for (int i = 0; i < 15; i++) wr(5'(i), 0, 48'(i * 3 + 1), "R9");
        cyc(1, 1, 0, 48'h0, 48'h1234_5678, 0, 0, "R9");
        wr(15, 0, 48'hF0F0, "R9");
        wr(6, 0, 48'h6666, "R9");
        cyc(1, 1, 2, 48'h0, 48'h1, 0, 0, "R9");
        cyc(1, 0, 7, 0, 48'h7777, 1, 0, "R9");
        cyc(0, 0, 0, 0, 0, 1, 0, "R9");

        // R3: pseudo-random traffic
        lf = 32'h1ACE_B00C;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cyc(lf[0] | lf[1], lf[2] & lf[3], 5'(lf[8:4] % 19),
                {lf[15:0], lf, lf[31:16]} & {48{lf[9]}}, {lf, lf[15:0]},
                lf[12] & lf[13] & lf[14], lf[20] & lf[21] & lf[22] & lf[23], "R3");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule